// File: doc/BRIEF.md
# BAR-to-AXI ingress address translator

This block sits between the receive side of a PCI Express endpoint and an on-chip memory-mapped bus. Each host request arrives already decoded to a BAR number and a byte offset inside that BAR. The block turns the request into a single 32-bit transfer on a simple AXI4-Lite style request/response channel pair. Software programs a small register file that lives inside the BAR0 window. That file holds a global bridge control word, a bridge base word and a set of translation regions. Each region ties one source BAR to a 4 KB aligned destination base.

When a request hits an enabled region and its offset lies inside the 4 KB aperture, the block swaps the BAR base for the destination base and keeps the low 12 offset bits. Any other request outside the register window gets an error response and causes no downstream traffic. The block handles one request at a time and relays downstream read data and error status back unchanged.

Top module: `ingress_xlat`

## Requirements
- R1: After reset all enables, sizes and bases read as zero. A request to any BAR other than the register window returns an error with no downstream transaction.
- R2: A BAR0 request at offset 0x8000 to 0x8FFF reaches the register file, with bridge-relative offset equal to the low 12 offset bits. Relative 0x208 is the bridge control word: bit 0 enables translation and bits 19:16 hold a size field. Relative 0x210 is a 32-bit bridge base word. Both read back as written. Register accesses complete with error flag 0 and no downstream transaction, and a write returns data 0.
- R3: Region n occupies relative 0x800 + 0x20*n. At +0x00 is a control word with bit 0 as enable and bits 18:16 as the source BAR. At +0x08 is the destination low word, whose bits 11:0 read as zero. At +0x0C is the destination high word.
- R4: While bridge control bit 0 is clear, writes to region registers are dropped and region registers read as zero.
- R5: A request qualifies for translation when its BAR is nonzero, bridge control bit 0 is set, an enabled region names that BAR, and its offset is below 0x1000. Such a request issues one downstream transfer at {dest high, dest low[31:12], offset[11:0]} with the same direction.
- R6: A request whose offset is 0x1000 or more is not translated. It returns error flag 1, and read data 0xFFFFFFFF, with no downstream transfer.
- R7: A request with no enabled matching region, or with bridge control bit 0 clear, returns error flag 1 and data 0xFFFFFFFF with no downstream transfer. A BAR0 request outside 0x8000 to 0x8FFF is handled the same way.
- R8: When several enabled regions name the same BAR, the lowest-numbered region supplies the destination.
- R9: req_ready is low from acceptance until the response cycle has passed. The downstream request stays valid, with stable address and data, until m_req_ready.
- R10: Write data goes downstream unchanged. Downstream read data and error flag are returned to the host unchanged.
- R11: A register access or a rejected request raises rsp_valid in the cycle right after acceptance, for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bar | input | 3 | BAR number hit by the request |
| req_off | input | OFF_W | Byte offset inside the BAR |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response carries an error |
| rsp_rdata | output | 32 | Read data |
| m_req_valid | output | 1 | Downstream request valid |
| m_req_ready | input | 1 | Downstream request taken |
| m_req_write | output | 1 | Downstream direction |
| m_req_addr | output | ADDR_W | Translated address |
| m_req_wdata | output | 32 | Downstream write data |
| m_rsp_valid | input | 1 | Downstream response strobe |
| m_rsp_err | input | 1 | Downstream error flag |
| m_rsp_rdata | input | 32 | Downstream read data |

## Verification
A corrupted region register shows up at the next translated request through that region, as a wrong m_req_addr in the cycle after acceptance. It also shows up directly in a read-back through the register window. A stuck or wrong gate bit turns every translated request into an error response one cycle after acceptance, or lets a request through that should have been blocked. A wrong control state shows as req_ready rising while a transfer is still outstanding, or as a request address that moves while a stalled transfer waits. The directed tests set stall and latency on the downstream side so that each of these effects reaches the ports within a few cycles.

// File: rtl/ingress_xlat_pkg.sv
package ingress_xlat_pkg;

   // bridge register window inside BAR0
   localparam logic [31:0] WIN_BASE   = 32'h0000_8000;
   localparam logic [11:0] REL_CTRL   = 12'h208;
   localparam logic [11:0] REL_BASELO = 12'h210;

   // region sets: 0x800 + 0x20*n, indexed by relative offset bits 11:5
   localparam logic [6:0]  RGN_IDX0   = 7'h40;
   localparam logic [4:0]  RGN_CTRL   = 5'h00;
   localparam logic [4:0]  RGN_DLO    = 5'h08;
   localparam logic [4:0]  RGN_DHI    = 5'h0C;

   localparam int unsigned APER_BITS  = 12;
   localparam int unsigned SIZE_W     = 4;

   typedef struct packed {
      logic        en;
      logic [2:0]  bar;
      logic [19:0] dlo;   // destination bits 31:12
      logic [31:0] dhi;   // destination bits 63:32
   } rgn_t;

   typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} xst_t;

endpackage

// File: rtl/ingress_xlat_regs.sv
module ingress_xlat_regs
   import ingress_xlat_pkg::*;
#(
   parameter int NREG = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_wr,
   input  logic [11:0]       rel,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              gate_en,
   output rgn_t [NREG-1:0]   rgn
);

   logic              en_q;
   logic [SIZE_W-1:0] size_q;
   logic [31:0]       base_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         size_q <= '0;
         base_q <= '0;
      end else if (acc_wr) begin
         if (rel == REL_CTRL) begin
            en_q   <= wdata[0];
            size_q <= wdata[16 +: SIZE_W];
         end
         if (rel == REL_BASELO)
            base_q <= wdata;
      end
   end

   assign gate_en = en_q;

   for (genvar i = 0; i < NREG; i++) begin : g_rgn
      localparam logic [6:0] IDX = RGN_IDX0 + 7'(i);
      rgn_t r_q;
      logic hit;
      assign hit = (rel[11:5] == IDX);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            r_q <= '0;
         end else if (acc_wr && hit && en_q) begin
            case (rel[4:0])
               RGN_CTRL: begin
                  r_q.en  <= wdata[0];
                  r_q.bar <= wdata[18:16];
               end
               RGN_DLO:  r_q.dlo <= wdata[31:12];
               RGN_DHI:  r_q.dhi <= wdata;
               default:  ;
            endcase
         end
      end

      assign rgn[i] = r_q;
   end

   always_comb begin
      rdata = '0;
      if (rel == REL_CTRL)
         rdata = {12'b0, size_q, 15'b0, en_q};
      else if (rel == REL_BASELO)
         rdata = base_q;
      for (int i = 0; i < NREG; i++) begin
         if (en_q && rel[11:5] == RGN_IDX0 + 7'(i)) begin
            case (rel[4:0])
               RGN_CTRL: rdata = {13'b0, rgn[i].bar, 15'b0, rgn[i].en};
               RGN_DLO:  rdata = {rgn[i].dlo, 12'b0};
               RGN_DHI:  rdata = rgn[i].dhi;
               default:  rdata = '0;
            endcase
         end
      end
   end

   // R4: region state frozen while the gate is off
   p_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && acc_wr && rel[11]) |=> $stable(rgn));

endmodule

// File: rtl/ingress_xlat_match.sv
module ingress_xlat_match
   import ingress_xlat_pkg::*;
#(
   parameter int NREG   = 2,
   parameter int OFF_W  = 32,
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_en,
   input  rgn_t [NREG-1:0]   rgn,
   input  logic [2:0]        req_bar,
   input  logic [OFF_W-1:0]  req_off,
   output logic              hit,
   output logic [ADDR_W-1:0] xaddr
);

   localparam int HI_W = ADDR_W - 32;

   logic            in_aper;
   logic [NREG-1:0] raw;
   logic [NREG-1:0] sel;

   assign in_aper = (req_off[OFF_W-1:APER_BITS] == '0);

   for (genvar i = 0; i < NREG; i++) begin : g_cmp
      assign raw[i] = gate_en && rgn[i].en && (rgn[i].bar == req_bar) && in_aper;
   end

   always_comb begin
      logic found;
      found = 1'b0;
      sel   = '0;
      for (int i = 0; i < NREG; i++) begin
         if (raw[i] && !found) begin
            sel[i] = 1'b1;
            found  = 1'b1;
         end
      end
   end

   always_comb begin
      xaddr = '0;
      for (int i = 0; i < NREG; i++)
         if (sel[i])
            xaddr = {rgn[i].dhi[HI_W-1:0], rgn[i].dlo, req_off[APER_BITS-1:0]};
   end

   assign hit = |sel;

   // R6: a hit never comes from an offset outside the aperture
   p_aper_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (req_off < OFF_W'(1 << APER_BITS)));

   // R8: at most one region selected
   p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));

endmodule

// File: rtl/ingress_xlat.sv
module ingress_xlat
   import ingress_xlat_pkg::*;
#(
   parameter int NREG   = 2,
   parameter int OFF_W  = 32,
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [2:0]        req_bar,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [31:0]       rsp_rdata,
   output logic              m_req_valid,
   input  logic              m_req_ready,
   output logic              m_req_write,
   output logic [ADDR_W-1:0] m_req_addr,
   output logic [31:0]       m_req_wdata,
   input  logic              m_rsp_valid,
   input  logic              m_rsp_err,
   input  logic [31:0]       m_rsp_rdata
);

   if (NREG < 1 || NREG > 32) begin : g_bad_nreg
      $error("ingress_xlat: NREG must be 1..32");
   end
   if (ADDR_W < 33 || ADDR_W > 64) begin : g_bad_addr
      $error("ingress_xlat: ADDR_W must be 33..64");
   end
   if (OFF_W < 16) begin : g_bad_off
      $error("ingress_xlat: OFF_W must be at least 16");
   end

   xst_t              st;
   logic              accept, in_win, go_xlat, go_local, acc_wr;
   logic              gate_en, hit;
   logic [31:0]       reg_rdata;
   logic [ADDR_W-1:0] xaddr;
   rgn_t [NREG-1:0]   rgn;

   assign req_ready = (st == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign in_win    = (req_bar == 3'd0) &&
                      (req_off[OFF_W-1:12] == (OFF_W-12)'(WIN_BASE >> 12));
   assign go_xlat   = !in_win && hit && (req_bar != 3'd0);
   assign go_local  = !go_xlat;
   assign acc_wr    = accept && in_win && req_write;

   ingress_xlat_regs #(.NREG(NREG)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_wr  (acc_wr),
      .rel     (req_off[11:0]),
      .wdata   (req_wdata),
      .rdata   (reg_rdata),
      .gate_en (gate_en),
      .rgn     (rgn)
   );

   ingress_xlat_match #(.NREG(NREG), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .gate_en (gate_en),
      .rgn     (rgn),
      .req_bar (req_bar),
      .req_off (req_off),
      .hit     (hit),
      .xaddr   (xaddr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         rsp_err     <= 1'b0;
         rsp_rdata   <= '0;
         m_req_write <= 1'b0;
         m_req_addr  <= '0;
         m_req_wdata <= '0;
      end else begin
         case (st)
            ST_IDLE: if (accept) begin
               if (in_win) begin
                  rsp_rdata <= req_write ? 32'h0 : reg_rdata;
                  rsp_err   <= 1'b0;
                  st        <= ST_RESP;
               end else if (go_xlat) begin
                  m_req_addr  <= xaddr;
                  m_req_write <= req_write;
                  m_req_wdata <= req_wdata;
                  st          <= ST_ISSUE;
               end else begin
                  rsp_rdata <= '1;
                  rsp_err   <= 1'b1;
                  st        <= ST_RESP;
               end
            end
            ST_ISSUE: if (m_req_ready) st <= ST_WAIT;
            ST_WAIT: if (m_rsp_valid) begin
               rsp_rdata <= m_rsp_rdata;
               rsp_err   <= m_rsp_err;
               st        <= ST_RESP;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign rsp_valid   = (st == ST_RESP);
   assign m_req_valid = (st == ST_ISSUE);

   // R9: one request outstanding
   p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);

   // R9: stalled downstream request holds its contents
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req_valid && !m_req_ready) |=>
         (m_req_valid && $stable(m_req_addr) && $stable(m_req_wdata) && $stable(m_req_write)));

   // R11: local answers come one cycle after acceptance
   p_local_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && go_local) |=> (rsp_valid && !m_req_valid));

   // R7: nothing goes downstream while the gate is off
   p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      m_req_valid |-> gate_en);

   // R11: response strobe lasts one cycle
   p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

// File: tb/tb_ingress_xlat.sv
module tb_ingress_xlat;

   localparam int CLK_PERIOD = 10;
   localparam int OFF_W  = 32;
   localparam int ADDR_W = 64;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              req_valid, req_write;
   logic              req_ready;
   logic [2:0]        req_bar;
   logic [OFF_W-1:0]  req_off;
   logic [31:0]       req_wdata;
   logic              rsp_valid, rsp_err;
   logic [31:0]       rsp_rdata;
   logic              m_req_valid, m_req_write;
   logic              m_req_ready;
   logic [ADDR_W-1:0] m_req_addr;
   logic [31:0]       m_req_wdata;
   logic              m_rsp_valid, m_rsp_err;
   logic [31:0]       m_rsp_rdata;

   int checks = 0;
   int errors = 0;

   // downstream model settings and observations
   int          sl_stall = 0;
   int          sl_lat   = 0;
   logic [31:0] sl_rdata = 32'h0;
   logic        sl_err   = 1'b0;
   int          n_tx     = 0;
   int          hold_bad = 0;
   logic [ADDR_W-1:0] cap_addr;
   logic        cap_write;
   logic [31:0] cap_wdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   ingress_xlat #(.NREG(2), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_bar(req_bar), .req_off(req_off), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_req_write(m_req_write),
      .m_req_addr(m_req_addr), .m_req_wdata(m_req_wdata),
      .m_rsp_valid(m_rsp_valid), .m_rsp_err(m_rsp_err), .m_rsp_rdata(m_rsp_rdata)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // downstream slave
   initial begin
      logic [ADDR_W-1:0] a0;
      m_req_ready = 1'b0;
      m_rsp_valid = 1'b0;
      m_rsp_err   = 1'b0;
      m_rsp_rdata = 32'h0;
      forever begin
         @(negedge clk);
         m_rsp_valid = 1'b0;
         if (m_req_valid) begin
            a0 = m_req_addr;
            for (int k = 0; k < sl_stall; k++) @(negedge clk);
            if (!m_req_valid || m_req_addr != a0) hold_bad++;
            cap_addr  = m_req_addr;
            cap_write = m_req_write;
            cap_wdata = m_req_wdata;
            n_tx++;
            m_req_ready = 1'b1;
            @(negedge clk);
            m_req_ready = 1'b0;
            for (int k = 0; k < sl_lat; k++) @(negedge clk);
            m_rsp_valid = 1'b1;
            m_rsp_rdata = sl_rdata;
            m_rsp_err   = sl_err;
         end
      end
   end

   // one host transfer; lat = negedges from acceptance to response
   task automatic xfer(input logic [2:0] bar, input logic [31:0] off, input bit wr,
                       input logic [31:0] wd, output logic [31:0] rd, output logic er,
                       output int lat, output int busy_bad);
      @(negedge clk);
      req_bar = bar; req_off = off; req_write = wr; req_wdata = wd; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      busy_bad = 0;
      while (!rsp_valid && lat < 100) begin
         if (req_ready) busy_bad++;
         @(negedge clk);
         lat++;
      end
      if (req_ready) busy_bad++;
      rd = rsp_rdata;
      er = rsp_err;
   endtask

   task automatic reg_wr(input logic [11:0] rel, input logic [31:0] d);
      logic [31:0] rd; logic er; int lat, bb;
      xfer(3'd0, 32'h8000 | 32'(rel), 1'b1, d, rd, er, lat, bb);
      chk(!er && lat == 1, "R11 register write answered next cycle, no error", 64'(lat), 64'd1);
   endtask

   task automatic reg_rd(input logic [11:0] rel, input logic [31:0] exp, input string tag);
      logic [31:0] rd; logic er; int lat, bb;
      xfer(3'd0, 32'h8000 | 32'(rel), 1'b0, 32'h0, rd, er, lat, bb);
      chk(rd == exp && !er, tag, 64'(rd), 64'(exp));
   endtask

   task automatic expect_err(input logic [2:0] bar, input logic [31:0] off, input bit wr, input string tag);
      logic [31:0] rd; logic er; int lat, bb, t0;
      t0 = n_tx;
      xfer(bar, off, wr, 32'h5555_AAAA, rd, er, lat, bb);
      chk(er && rd == 32'hFFFF_FFFF && lat == 1, tag, {31'b0, er, rd}, {32'h1, 32'hFFFF_FFFF});
      @(negedge clk);
      chk(n_tx == t0, {tag, " (no downstream)"}, 64'(n_tx), 64'(t0));
   endtask

   task automatic t_reset;
      chk(req_ready && !rsp_valid && !m_req_valid, "R1 idle outputs after reset",
          {61'b0, req_ready, rsp_valid, m_req_valid}, 64'h4);
      reg_rd(12'h208, 32'h0, "R1 bridge control clear");
      reg_rd(12'h210, 32'h0, "R1 bridge base clear");
      expect_err(3'd2, 32'h10, 1'b0, "R1 BAR2 rejected after reset");
   endtask

   task automatic t_lock;
      reg_wr(12'h800, 32'h0002_0001);
      reg_rd(12'h800, 32'h0, "R4 region read zero while gate off");
      reg_wr(12'h208, 32'h0000_0001);
      reg_rd(12'h800, 32'h0, "R4 region write while gate off was dropped");
   endtask

   task automatic t_regs;
      reg_wr(12'h208, 32'hFFF5_FFFF);
      reg_rd(12'h208, 32'h0005_0001, "R2 control readback size/enable");
      reg_wr(12'h210, 32'h1234_8000);
      reg_rd(12'h210, 32'h1234_8000, "R2 base-low readback");
      chk(n_tx == 0, "R2 register accesses issue no downstream", 64'(n_tx), 64'd0);
   endtask

   task automatic t_regions;
      reg_wr(12'h800, 32'h0002_0001);
      reg_wr(12'h808, 32'h44A0_0ABC);
      reg_wr(12'h80C, 32'h0000_0000);
      reg_wr(12'h820, 32'h0004_0001);
      reg_wr(12'h828, 32'hC000_0123);
      reg_wr(12'h82C, 32'h0000_0012);
      reg_rd(12'h800, 32'h0002_0001, "R3 region0 control");
      reg_rd(12'h808, 32'h44A0_0000, "R3 region0 dest low aligned");
      reg_rd(12'h820, 32'h0004_0001, "R3 region1 control");
      reg_rd(12'h828, 32'hC000_0000, "R3 region1 dest low aligned");
      reg_rd(12'h82C, 32'h0000_0012, "R3 region1 dest high");
   endtask

   task automatic t_translate;
      logic [31:0] rd; logic er; int lat, bb;
      sl_stall = 2; sl_lat = 3; sl_rdata = 32'hDEAD_BEEF; sl_err = 1'b0;
      xfer(3'd2, 32'h0000_0010, 1'b0, 32'h0, rd, er, lat, bb);
      chk(cap_addr == 64'h0000_0000_44A0_0010 && !cap_write, "R5 BAR2 read translated",
          cap_addr, 64'h0000_0000_44A0_0010);
      chk(rd == 32'hDEAD_BEEF && !er, "R10 read data passed back", 64'(rd), 64'hDEAD_BEEF);
      chk(bb == 0, "R9 req_ready low while outstanding", 64'(bb), 64'd0);
      sl_stall = 0; sl_lat = 0;
      xfer(3'd4, 32'h0000_0FFC, 1'b1, 32'h1357_9BDF, rd, er, lat, bb);
      chk(cap_addr == 64'h0000_0012_C000_0FFC && cap_write, "R5 BAR4 write at aperture top",
          cap_addr, 64'h0000_0012_C000_0FFC);
      chk(cap_wdata == 32'h1357_9BDF, "R10 write data unchanged", 64'(cap_wdata), 64'h1357_9BDF);
      sl_err = 1'b1; sl_lat = 1;
      xfer(3'd2, 32'h0000_0020, 1'b0, 32'h0, rd, er, lat, bb);
      chk(er == 1'b1, "R10 downstream error passed back", 64'(er), 64'd1);
      sl_err = 1'b0;
      chk(n_tx == 3 && hold_bad == 0, "R9 stalled request held, one transfer each",
          64'(hold_bad), 64'd0);
   endtask

   task automatic t_aperture;
      expect_err(3'd2, 32'h0000_1000, 1'b0, "R6 read at offset 0x1000 rejected");
      expect_err(3'd4, 32'h0001_0004, 1'b1, "R6 write beyond aperture dropped");
   endtask

   task automatic t_nomatch;
      expect_err(3'd1, 32'h0000_0004, 1'b0, "R7 BAR1 has no region");
      expect_err(3'd0, 32'h0000_0100, 1'b0, "R7 BAR0 below window");
      expect_err(3'd0, 32'h0000_9000, 1'b0, "R7 BAR0 above window");
      reg_wr(12'h208, 32'h0000_0000);
      expect_err(3'd2, 32'h0000_0010, 1'b0, "R7 gate off blocks translation");
      reg_wr(12'h208, 32'h0000_0001);
   endtask

   task automatic t_prio;
      logic [31:0] rd; logic er; int lat, bb;
      reg_wr(12'h820, 32'h0002_0001);
      xfer(3'd2, 32'h0000_0044, 1'b0, 32'h0, rd, er, lat, bb);
      chk(cap_addr == 64'h0000_0000_44A0_0044, "R8 lower region wins", cap_addr, 64'h0000_0000_44A0_0044);
      reg_wr(12'h800, 32'h0002_0000);
      xfer(3'd2, 32'h0000_0044, 1'b0, 32'h0, rd, er, lat, bb);
      chk(cap_addr == 64'h0000_0012_C000_0044, "R8 region1 used once region0 disabled",
          cap_addr, 64'h0000_0012_C000_0044);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      req_valid = 1'b0; req_write = 1'b0; req_bar = '0; req_off = '0; req_wdata = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_lock();
      t_regs();
      t_regions();
      t_translate();
      t_aperture();
      t_nomatch();
      t_prio();
      repeat (4) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule